// File: doc/BRIEF.md
# Descriptor-Fetching DMA Engine

This block is a single-channel DMA engine. It is controlled through a command block that lives in memory. Software places a four-word command block there and writes the block's address into one pointer register. The engine then becomes a master on a request/grant memory bus. It reads the command block, copies the requested number of bytes one at a time, and raises an interrupt when the count reaches zero. The processor does no work for the individual bytes. The engine borrows bus cycles only when the arbiter grants them.

The command block holds four consecutive 32-bit words at the pointer, pointer+4, pointer+8 and pointer+12. In that order they are a first address (A), a second address (B), a mode word and a byte count. In mode bit 0, a 1 moves bytes from A to B. A 0 reverses the direction, so bytes move from B to A. In mode bit 1, a 1 keeps the read address fixed, which suits a device data port. A 0 makes the read address increment. The write address always increments. The slave side has a pointer register and a status register. The status register shows the busy state, the pending interrupt and a sticky overrun flag. It also clears those flags on a write.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset, bus_req_o and irq_o are low and the status register (offset 1) reads 0.
- R2: A write to offset 0 while idle stores the pointer and starts a transfer. The first four bus accesses are word reads (bus_size_o=1, bus_we_o=0) at pointer, pointer+4, pointer+8 and pointer+12, in that order.
- R3: Once bus_req_o is high, it stays high, with bus_addr_o and bus_we_o stable, until bus_gnt_i is high. The access completes in that cycle. bus_req_o is then low for at least one cycle after every completed access.
- R4: With mode bit 0 = 1, the engine copies count bytes from ascending addresses starting at A to ascending addresses starting at B. It uses byte accesses and carries the data in bits 7:0.
- R5: With mode bit 0 = 0, the roles reverse: bytes are read from B and written to A.
- R6: With mode bit 1 = 1, every data read uses the same read address, so each destination byte equals the byte at that address.
- R7: A transfer makes exactly 4 + 2*count bus accesses. Only the low CNT_W (16) bits of the count word are used. No byte beyond the count is written.
- R8: A count of zero ends the transfer after the four command-block reads, with no data access, and raises irq_o.
- R9: irq_o rises when a transfer ends. It stays high until software writes status with bit 1 set. Status bit 1 mirrors it.
- R10: A write to offset 0 while busy does not change the running transfer. It sets status bit 2, which stays set until a status write with bit 2 set. Status bit 0 reads 1 while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset (0 pointer, 1 status) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| bus_req_o | output | 1 | Bus request, and access valid |
| bus_gnt_i | input | 1 | Bus grant; the access completes when high with the request |
| bus_we_o | output | 1 | 1 = write access |
| bus_size_o | output | 1 | 1 = 32-bit word, 0 = byte in bits 7:0 |
| bus_addr_o | output | AW | Byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_rdata_i | input | 32 | Read data, sampled in the completing cycle |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bound checker checks the bus handshake on every cycle: the request is held with a stable address, and it drops after each grant. It also checks on every cycle that the interrupt stays held, that it rises only at the end of a transfer, and that a pointer write during a busy period sets the overrun flag. Several results appear only through the bench's scenarios, which compare memory contents and the access log against a model: the data copied in each direction, the fixed-source mode, the count truncation, the zero-count case, and the fact that an overrunning pointer is ignored.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_RD, ST_WR, ST_DONE
  } dma_state_e;

  localparam logic [1:0] REG_PTR  = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;

  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_IRQ  = 1;
  localparam int unsigned STAT_OVR  = 2;

  localparam int unsigned MODE_FWD = 0;
  localparam int unsigned MODE_FIX = 1;

  localparam int unsigned DESC_WORDS = 4;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          busy_i,
  input  logic          done_i,
  output logic          start_o,
  output logic [AW-1:0] ptr_o,
  output logic          irq_o,
  output logic          ovr_o
);
  logic [AW-1:0] ptr_q;
  logic          irq_q, ovr_q;
  logic          wr_ptr, wr_stat;

  assign wr_ptr  = reg_wr_i && (reg_addr_i == REG_PTR);
  assign wr_stat = reg_wr_i && (reg_addr_i == REG_STAT);
  assign start_o = wr_ptr && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (start_o) ptr_q <= reg_wdata_i[AW-1:0];
      // set wins over a same-cycle clear
      if (done_i) irq_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[STAT_IRQ]) irq_q <= 1'b0;
      if (wr_ptr && busy_i) ovr_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[STAT_OVR]) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      REG_PTR:  reg_rdata_o[AW-1:0] = ptr_q;
      REG_STAT: begin
        reg_rdata_o[STAT_BUSY] = busy_i;
        reg_rdata_o[STAT_IRQ]  = irq_q;
        reg_rdata_o[STAT_OVR]  = ovr_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  assign ptr_o = ptr_q;
  assign irq_o = irq_q;
  assign ovr_o = ovr_q;
endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
  import dma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] ptr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_we_o,
  output logic          bus_size_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [31:0]   bus_wdata_o,
  input  logic [31:0]   bus_rdata_i
);
  localparam int unsigned IDX_W = $clog2(DESC_WORDS);

  dma_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             gap_q, fix_q, acc, in_acc;
  logic [AW-1:0]    rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q, cnt_new;
  logic [7:0]       byte_q;

  assign in_acc    = (state_q == ST_FETCH) || (state_q == ST_RD) || (state_q == ST_WR);
  assign bus_req_o = in_acc && !gap_q;
  assign acc       = bus_req_o && bus_gnt_i;
  assign cnt_new   = bus_rdata_i[CNT_W-1:0];

  always_comb begin
    bus_we_o    = (state_q == ST_WR);
    bus_size_o  = (state_q == ST_FETCH);
    bus_wdata_o = {24'b0, byte_q};
    unique case (state_q)
      ST_FETCH: bus_addr_o = ptr_i + AW'({idx_q, 2'b00});
      ST_RD:    bus_addr_o = rd_ptr_q;
      ST_WR:    bus_addr_o = wr_ptr_q;
      default:  bus_addr_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      gap_q    <= 1'b0;
      fix_q    <= 1'b0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
      byte_q   <= '0;
    end else begin
      gap_q <= acc;  // give the bus back for one cycle after each access
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_FETCH;
          idx_q   <= '0;
        end
        ST_FETCH: if (acc) begin
          idx_q <= idx_q + 1'b1;
          unique case (idx_q)
            2'd0: rd_ptr_q <= bus_rdata_i[AW-1:0];
            2'd1: wr_ptr_q <= bus_rdata_i[AW-1:0];
            2'd2: begin
              fix_q <= bus_rdata_i[MODE_FIX];
              if (!bus_rdata_i[MODE_FWD]) begin
                rd_ptr_q <= wr_ptr_q;
                wr_ptr_q <= rd_ptr_q;
              end
            end
            default: begin
              cnt_q   <= cnt_new;
              state_q <= (cnt_new == '0) ? ST_DONE : ST_RD;
            end
          endcase
        end
        ST_RD: if (acc) begin
          byte_q  <= bus_rdata_i[7:0];
          if (!fix_q) rd_ptr_q <= rd_ptr_q + AW'(1);
          state_q <= ST_WR;
        end
        ST_WR: if (acc) begin
          wr_ptr_q <= wr_ptr_q + AW'(1);
          cnt_q    <= cnt_q - 1'b1;
          state_q  <= (cnt_q == CNT_W'(1)) ? ST_DONE : ST_RD;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
  import dma_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  output logic          bus_req_o,
  input  logic          bus_gnt_i,
  output logic          bus_we_o,
  output logic          bus_size_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [31:0]   bus_wdata_o,
  input  logic [31:0]   bus_rdata_i,
  output logic          irq_o
);
  logic          busy, done, start, ovr;
  logic [AW-1:0] ptr;

  dma_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .done_i(done), .start_o(start), .ptr_o(ptr),
    .irq_o, .ovr_o(ovr)
  );

  dma_ctrl #(.AW(AW), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i(start), .ptr_i(ptr),
    .busy_o(busy), .done_o(done),
    .bus_req_o, .bus_gnt_i, .bus_we_o, .bus_size_o,
    .bus_addr_o, .bus_wdata_o, .bus_rdata_i
  );
endmodule

// File: rtl/dma_desc_engine_chk.sv
module dma_desc_engine_chk
  import dma_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_wr_i,
  input logic [1:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          irq_o,
  input logic          busy_i,
  input logic          ovr_i
);
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o));
  // R3
  req_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i |=> !bus_req_o);
  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(reg_wr_i && reg_addr_i == REG_STAT && reg_wdata_i[STAT_IRQ]) |=> irq_o);
  // R9
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(busy_i));
  // R10
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == REG_PTR && busy_i |=> ovr_i);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !bus_req_o);
endmodule

bind dma_desc_engine dma_desc_engine_chk #(.AW(AW)) u_chk (
  .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i,
  .bus_req_o, .bus_gnt_i, .bus_we_o, .bus_addr_o, .irq_o,
  .busy_i(busy), .ovr_i(ovr)
);

// File: tb/sim_dma_desc_engine.sv
`timescale 1ns/1ps
module sim_dma_desc_engine;
  localparam int unsigned AW = 32;
  localparam int unsigned MEM_N = 1024;
  localparam int unsigned LOG_N = 4096;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = 2'd0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        bus_req_o, bus_gnt_i = 1'b0, bus_we_o, bus_size_o, irq_o;
  logic [AW-1:0] bus_addr_o;
  logic [31:0] bus_wdata_o, bus_rdata_i;

  int total = 0, bad = 0, acc_cnt = 0;
  logic [7:0]  mem [MEM_N];
  logic [7:0]  snap [64];
  logic [31:0] log_addr [LOG_N];
  logic        log_we [LOG_N];
  logic        log_size [LOG_N];

  always #10 clk_i = ~clk_i;  // 50 MHz

  dma_desc_engine #(.AW(AW), .CNT_W(16)) u0 (.*);

  logic [9:0] a0, a1, a2, a3;
  assign a0 = bus_addr_o[9:0];
  assign a1 = a0 + 10'd1;
  assign a2 = a0 + 10'd2;
  assign a3 = a0 + 10'd3;
  assign bus_rdata_i = bus_size_o ? {mem[a3], mem[a2], mem[a1], mem[a0]} : {24'b0, mem[a0]};

  always @(posedge clk_i) begin
    if (bus_req_o && bus_gnt_i) begin
      log_addr[acc_cnt % LOG_N] <= bus_addr_o;
      log_we[acc_cnt % LOG_N]   <= bus_we_o;
      log_size[acc_cnt % LOG_N] <= bus_size_o;
      if (bus_we_o) mem[a0] <= bus_wdata_o[7:0];
      acc_cnt = acc_cnt + 1;
    end
  end

  always @(negedge clk_i) bus_gnt_i <= (($urandom % 4) != 0);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic put_word(input int unsigned at, input logic [31:0] w);
    for (int i = 0; i < 4; i++) mem[(at + i) % MEM_N] = w[8*i +: 8];
  endtask

  function automatic int unsigned rd_base(input logic [31:0] a, b, mode);
    return mode[0] ? a : b;
  endfunction
  function automatic int unsigned wr_base(input logic [31:0] a, b, mode);
    return mode[0] ? b : a;
  endfunction
  function automatic logic [7:0] exp_byte(input logic [31:0] mode, input int i);
    return mode[1] ? snap[0] : snap[i];
  endfunction

  task automatic run_xfer(input int unsigned dp, input logic [31:0] a, b, mode, cword,
                          input bit ovr_test);
    int unsigned rb, wb, cnt, s, to;
    logic [31:0] st;
    cnt = cword[15:0];
    rb = rd_base(a, b, mode);
    wb = wr_base(a, b, mode);
    put_word(dp, a); put_word(dp + 4, b); put_word(dp + 8, mode); put_word(dp + 12, cword);
    for (int i = 0; i < 64; i++) begin
      snap[i] = 8'($urandom);
      mem[(rb + i) % MEM_N] = snap[i];
      mem[(wb + i) % MEM_N] = 8'h00;
    end
    s = acc_cnt;
    reg_write(REG_PTR_A, dp);
    if (ovr_test) begin
      reg_write(REG_PTR_A, 32'h40);
      reg_read(REG_STAT_A, st);
      // R10 overrun flag and busy bit while running
      chk(st[2] && st[0], "R10 overrun/busy", st, 32'h5);
    end
    to = 0;
    while (!irq_o && to < 20000) begin @(negedge clk_i); to++; end
    chk(irq_o, "R9 irq at end", irq_o, 1);
    // R2 descriptor fetch order
    for (int k = 0; k < 4; k++)
      chk(log_addr[(s + k) % LOG_N] == dp + 4 * k && log_size[(s + k) % LOG_N] && !log_we[(s + k) % LOG_N],
          "R2 fetch", log_addr[(s + k) % LOG_N], dp + 4 * k);
    // R7 access count
    chk(acc_cnt - s == 4 + 2 * cnt, "R7 accesses", acc_cnt - s, 4 + 2 * cnt);
    // R4 R5 R6 copied data
    for (int i = 0; i < int'(cnt); i++)
      chk(mem[(wb + i) % MEM_N] == exp_byte(mode, i),
          mode[1] ? "R6 fixed src" : (mode[0] ? "R4 fwd copy" : "R5 rev copy"),
          mem[(wb + i) % MEM_N], exp_byte(mode, i));
    // R7 nothing past count
    for (int i = int'(cnt); i < int'(cnt) + 2; i++)
      chk(mem[(wb + i) % MEM_N] == 8'h00, "R7 overrun write", mem[(wb + i) % MEM_N], 0);
    repeat (5) @(negedge clk_i);
    reg_read(REG_STAT_A, st);
    chk(irq_o && st[1] && !st[0], "R9 irq held", st, 32'h2);
    reg_write(REG_STAT_A, 32'h6);
    reg_read(REG_STAT_A, st);
    chk(!irq_o && st == 0, "R9 R10 clear", st, 0);
  endtask

  localparam logic [1:0] REG_PTR_A = 2'd0;
  localparam logic [1:0] REG_STAT_A = 2'd1;

  initial begin
    logic [31:0] st;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    #1;
    chk(!bus_req_o && !irq_o, "R1 reset outputs", {bus_req_o, irq_o}, 0);
    rst_ni = 1'b1;
    reg_read(REG_STAT_A, st);
    chk(st == 0, "R1 reset status", st, 0);
    // directed corner cases
    run_xfer(32'h000, 32'h100, 32'h200, 32'h1, 32'd1, 1'b0);
    run_xfer(32'h010, 32'h100, 32'h200, 32'h1, 32'd0, 1'b0);          // R8 zero count
    run_xfer(32'h020, 32'h100, 32'h200, 32'h0, 32'd9, 1'b0);          // R5
    run_xfer(32'h030, 32'h120, 32'h240, 32'h3, 32'd7, 1'b0);          // R6
    run_xfer(32'h050, 32'h100, 32'h200, 32'h1, 32'h0001_0003, 1'b0);  // R7 truncation
    run_xfer(32'h060, 32'h100, 32'h200, 32'h1, 32'd12, 1'b1);         // R10 ignored
    run_xfer(32'h070, 32'h100, 32'h200, 32'h1, 32'h0001_0000, 1'b0);  // R8 via truncation
    // random mix
    for (int n = 0; n < 20; n++)
      run_xfer(32'h080 + 16 * (n % 8), 32'h100 + ($urandom % 8), 32'h200 + ($urandom % 8),
               {$urandom} & 32'hFFFF_FFF3 | ($urandom % 4), $urandom % 48, ($urandom % 4) == 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule